// File: doc/BRIEF.md
# Processor Clock Enable Generator

This block sets the pace of a processor from one fast reference clock. The clock is never gated. The block produces a one-cycle enable pulse, and the processor's registers advance only on cycles where that pulse is high. The rate has two parts. A prescale stage divides the reference by 2, 3 or 4, as chosen by a two-bit ratio select. A binary stage then divides further by a power of two, as chosen by a three-bit divider select. The exponent saturates, so the two highest divider codes give the same rate.

With a 19.6608 MHz reference, divider code 0 gives rates of 9.8304 MHz, 6.5536 MHz and 4.9152 MHz for the three legal ratio settings. The slowest rates are 153.6 kHz, 102.4 kHz and 76.8 kHz. Both selects come from register fields that may change at any time. The block captures them only when an output period ends, so no period is ever cut short or stretched. A second output toggles on every enable pulse. It gives a square wave that can be used for observation.

Top module: `cpu_clken_gen`

## Requirements
- R1: The ratio select sets the prescale divisor. Code 2'b10 divides by 2, 2'b01 divides by 3 and 2'b00 divides by 4. At divider code 0 the enable period is 2, 3 or 4 reference cycles.
- R2: For divider codes 0 to 6, each step up in the code doubles the enable period. The period is the prescale divisor times 2 raised to the code.
- R3: Divider code 7 gives the same period as code 6 for every ratio setting.
- R4: The unused ratio code 2'b11 behaves exactly like 2'b00, the slowest setting.
- R5: `clk_en` is high for exactly one reference cycle in each enable period and is low on every other cycle.
- R6: `obs_clk` changes level in exactly those cycles in which `clk_en` is high. This makes it a 50% duty square wave at half the enable rate.
- R7: New select values take effect only at the end of a period. The period in progress keeps its old length, and the next period has the full new length.
- R8: While `rst` is high, `clk_en` and `obs_clk` are 0 and the captured selects become ratio 2'b00 and divider 0. After release, the first `clk_en` pulse is seen in the cycle that follows the 4th rising edge with `rst` low. The select inputs are taken only at that first pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst | input | 1 | Synchronous reset, active high |
| ratio_sel | input | 2 | Ratio select: 10 gives /2, 01 gives /3, 00 or 11 gives /4 |
| div_sel | input | DIV_W (3) | Power-of-two divider code, saturating at MAX_EXP (6) |
| clk_en | output | 1 | One-cycle enable pulse, once per period |
| obs_clk | output | 1 | Toggles on each enable pulse |

## Verification
The assertions check these points on every cycle: each enable pulse lasts one cycle, the observation output toggles only when an enable pulse occurs, the captured selects never change except at a period end, every period end leads to a pulse, and no gap between pulses exceeds the longest legal period. The exact period for each ratio and divider pair, the saturation of code 7 and the aliasing of the unused ratio code can only be shown by the bench, which measures pulse spacing. The same holds for the rule that a change made mid-period waits for the period to end, and for the fixed length of the first period after reset.

// File: rtl/cpu_clken_pkg.sv
package cpu_clken_pkg;

  localparam int RATIO_W = 2;
  localparam int PRE_W   = 3;

  typedef enum logic [RATIO_W-1:0] {
    RAT_QUARTER = 2'b00,
    RAT_THIRD   = 2'b01,
    RAT_HALF    = 2'b10,
    RAT_UNUSED  = 2'b11
  } ratio_e;

  // Terminal count of the prescale counter (divisor minus one).
  function automatic logic [PRE_W-1:0] pre_limit(input ratio_e r);
    case (r)
      RAT_HALF:  pre_limit = PRE_W'(1);
      RAT_THIRD: pre_limit = PRE_W'(2);
      default:   pre_limit = PRE_W'(3);  // RAT_QUARTER and RAT_UNUSED
    endcase
  endfunction

endpackage

// File: rtl/cpu_clken_prescale.sv
module cpu_clken_prescale
  import cpu_clken_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [PRE_W-1:0] limit,
  output logic             wrap
);

  logic [PRE_W-1:0] cnt_q;

  assign wrap = (cnt_q == limit);

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (wrap) cnt_q <= '0;
    else           cnt_q <= cnt_q + PRE_W'(1);
  end

endmodule

// File: rtl/cpu_clken_binary.sv
module cpu_clken_binary #(
  parameter int EXP_W   = 3,
  parameter int MAX_EXP = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic [EXP_W-1:0] exp_sel,
  output logic             period_end
);

  localparam int CNT_W = MAX_EXP + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_val;
  logic             at_last;

  // Terminal count is 2**exp - 1: the low exp bits set.
  for (genvar g = 0; g < CNT_W; g++) begin : g_mask
    assign last_val[g] = (exp_sel > EXP_W'(g));
  end

  assign at_last    = (cnt_q == last_val);
  assign period_end = step && at_last;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (period_end)   cnt_q <= '0;
    else if (step)         cnt_q <= cnt_q + CNT_W'(1);
  end

endmodule

// File: rtl/cpu_clken_gen.sv
module cpu_clken_gen
  import cpu_clken_pkg::*;
#(
  parameter int DIV_W   = 3,
  parameter int MAX_EXP = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [RATIO_W-1:0] ratio_sel,
  input  logic [DIV_W-1:0]   div_sel,
  output logic               clk_en,
  output logic               obs_clk
);

  ratio_e           cfg_ratio_q;
  logic [DIV_W-1:0] cfg_div_q;
  logic [DIV_W-1:0] exp_sat;
  logic [PRE_W-1:0] pre_lim;
  logic             pre_wrap;
  logic             period_end;

  assign pre_lim = pre_limit(cfg_ratio_q);
  assign exp_sat = (cfg_div_q > DIV_W'(MAX_EXP)) ? DIV_W'(MAX_EXP) : cfg_div_q;

  cpu_clken_prescale u_pre (
    .clk   (clk),
    .rst   (rst),
    .limit (pre_lim),
    .wrap  (pre_wrap)
  );

  cpu_clken_binary #(
    .EXP_W   (DIV_W),
    .MAX_EXP (MAX_EXP)
  ) u_bin (
    .clk        (clk),
    .rst        (rst),
    .step       (pre_wrap),
    .exp_sel    (exp_sat),
    .period_end (period_end)
  );

  // Selects are captured only at a period boundary; both counters wrap there.
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_ratio_q <= RAT_QUARTER;
      cfg_div_q   <= '0;
      clk_en      <= 1'b0;
      obs_clk     <= 1'b0;
    end else begin
      clk_en <= period_end;
      if (period_end) begin
        cfg_ratio_q <= ratio_e'(ratio_sel);
        cfg_div_q   <= div_sel;
        obs_clk     <= ~obs_clk;
      end
    end
  end

endmodule

// File: rtl/cpu_clken_gen_chk.sv
module cpu_clken_gen_chk
  import cpu_clken_pkg::*;
#(
  parameter int DIV_W   = 3,
  parameter int MAX_EXP = 6
) (
  input logic               clk,
  input logic               rst,
  input logic               clk_en,
  input logic               obs_clk,
  input logic               period_end,
  input ratio_e             cfg_ratio_q,
  input logic [DIV_W-1:0]   cfg_div_q
);

  localparam int MAX_PERIOD = 4 << MAX_EXP;
  localparam int GAP_W      = $clog2(MAX_PERIOD + 2) + 1;

  logic [GAP_W-1:0] gap_q;

  always_ff @(posedge clk) begin
    if (rst)                               gap_q <= '0;
    else if (clk_en)                       gap_q <= GAP_W'(1);
    else if (gap_q != {GAP_W{1'b1}})       gap_q <= gap_q + GAP_W'(1);
  end

  // R5: the enable pulse lasts a single cycle
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
    clk_en |=> !clk_en);

  // R5: pulse spacing never exceeds the slowest period
  a_r5_max_gap: assert property (@(posedge clk) disable iff (rst)
    gap_q <= GAP_W'(MAX_PERIOD));

  // R6: observation output changes exactly when the enable is high
  a_r6_obs_toggle: assert property (@(posedge clk) disable iff (rst)
    (obs_clk != $past(obs_clk)) == clk_en);

  // R7: captured selects hold except at a period end
  a_r7_cfg_hold: assert property (@(posedge clk) disable iff (rst)
    !period_end |=> ($stable(cfg_ratio_q) && $stable(cfg_div_q)));

  // R7: every period end produces an enable pulse
  a_r7_end_pulse: assert property (@(posedge clk) disable iff (rst)
    period_end |=> clk_en);

  // R8: outputs quiet after a reset cycle
  a_r8_reset_quiet: assert property (@(posedge clk)
    rst |=> (!clk_en && !obs_clk));

endmodule

bind cpu_clken_gen cpu_clken_gen_chk #(
  .DIV_W   (DIV_W),
  .MAX_EXP (MAX_EXP)
) chk_i (
  .clk         (clk),
  .rst         (rst),
  .clk_en      (clk_en),
  .obs_clk     (obs_clk),
  .period_end  (period_end),
  .cfg_ratio_q (cfg_ratio_q),
  .cfg_div_q   (cfg_div_q)
);

// File: tb/cpu_clken_gen_tb_top.sv
`timescale 1ns/1ps
module cpu_clken_gen_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] ratio_sel = 2'b00;
  logic [2:0] div_sel = 3'd0;
  logic       clk_en;
  logic       obs_clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  cpu_clken_gen dut_i (
    .clk       (clk),
    .rst       (rst),
    .ratio_sel (ratio_sel),
    .div_sel   (div_sel),
    .clk_en    (clk_en),
    .obs_clk   (obs_clk)
  );

  // {ratio[13:12], div[11:9], expected period[8:0]}
  localparam int NVEC = 13;
  localparam logic [13:0] VEC [NVEC] = '{
    {2'b10, 3'd0, 9'd2},    // R1
    {2'b01, 3'd0, 9'd3},    // R1
    {2'b00, 3'd0, 9'd4},    // R1
    {2'b10, 3'd3, 9'd16},   // R2
    {2'b01, 3'd1, 9'd6},    // R2
    {2'b01, 3'd5, 9'd96},   // R2
    {2'b00, 3'd2, 9'd16},   // R2
    {2'b10, 3'd6, 9'd128},  // R2
    {2'b10, 3'd7, 9'd128},  // R3
    {2'b01, 3'd7, 9'd192},  // R3
    {2'b00, 3'd6, 9'd256},  // R2
    {2'b11, 3'd0, 9'd4},    // R4
    {2'b11, 3'd7, 9'd256}   // R4 R3
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Advance to the next negedge at which clk_en is high.
  task automatic next_pulse(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!clk_en && n < 2000);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    int n;
    int n2;
    logic o1;

    // R8: reset state
    repeat (3) @(negedge clk);
    check(clk_en == 1'b0, "R8 en in reset", clk_en, 0);
    check(obs_clk == 1'b0, "R8 obs in reset", obs_clk, 0);
    ratio_sel = 2'b10; div_sel = 3'd0;
    rst = 1'b0;
    next_pulse(n);
    check(n == 4, "R8 first pulse delay", n, 4);
    // select captured at the first pulse: next period uses /2
    next_pulse(n);
    check(n == 2, "R8 capture at first pulse", n, 2);

    // Vector walk
    for (int i = 0; i < NVEC; i++) begin
      ratio_sel = VEC[i][13:12];
      div_sel   = VEC[i][11:9];
      next_pulse(n);                 // capture edge
      o1 = obs_clk;
      next_pulse(n);
      check(n == int'(VEC[i][8:0]), $sformatf("R2 period vec%0d", i), n, int'(VEC[i][8:0]));
      check(obs_clk == ~o1, $sformatf("R6 obs toggle vec%0d", i), obs_clk, ~o1);
      @(negedge clk);
      check(clk_en == 1'b0, $sformatf("R5 pulse width vec%0d", i), clk_en, 0);
      o1 = obs_clk;
      next_pulse(n2);
      check(n2 == n + 0 - 1 + 1 - 1 || n2 == n - 1, $sformatf("R5 steady period vec%0d", i), n2 + 1, n);
      check(obs_clk == ~o1, $sformatf("R6 obs second toggle vec%0d", i), obs_clk, ~o1);
    end

    // R7: mid-period change keeps the current period length
    ratio_sel = 2'b00; div_sel = 3'd6;
    next_pulse(n);
    next_pulse(n);
    check(n == 256, "R7 setup period", n, 256);
    repeat (10) @(negedge clk);
    ratio_sel = 2'b10; div_sel = 3'd0;
    next_pulse(n);
    check(n + 10 == 256, "R7 old period kept", n + 10, 256);
    next_pulse(n);
    check(n == 2, "R7 full new period", n, 2);

    // R8: reset mid-run returns to /4 for the first period
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check(clk_en == 1'b0 && obs_clk == 1'b0, "R8 reset clears outputs", {clk_en, obs_clk}, 0);
    ratio_sel = 2'b01; div_sel = 3'd1;
    rst = 1'b0;
    next_pulse(n);
    check(n == 4, "R8 first period after reset", n, 4);
    next_pulse(n);
    check(n == 6, "R7 R8 captured select after reset", n, 6);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule